// File: doc/BRIEF.md
# Motor Tachometer Output Controller

This block drives the speed-feedback pin of a sensorless three-phase motor controller. While the drive is running, the pin is built from a half-cycle tick that the commutation logic sends twice per electrical cycle. A select bit picks one of two rates. At the direct rate, the pin completes one period per electrical cycle. At the divided rate, it completes one period per three electrical cycles. This holds in open-loop acceleration too, where the tick comes from the drive waveform. In that phase the pin can toggle even though the rotor is stalled.

When the drive is in closed-loop operation and the commanded duty falls to zero, the motor coasts. During coast the pin follows the U-phase back-EMF comparator, taken through a synchronizer. The block times the gap between back-EMF zero-cross strobes. When no strobe arrives within a programmed window (the clock-cycle equivalent of 100 ms, which corresponds to a 10 Hz speed floor), the block raises a sleep request. It then holds the pin at the comparator level captured at the last zero-cross, until a new start sequence with non-zero duty begins.

Top module: `tach_feedback`

## Requirements
- R1: While rstN is low, and on the first cycle after its release, fgOut is 0 and sleepReq is 0.
- R2: In the run state with divSel = 0, every cycle that has halfTick high inverts fgOut at the next clock edge. No other cycle changes fgOut.
- R3: In the run state with divSel = 1, fgOut inverts at the edge that ends every third halfTick cycle, counted from a cleared phase. The other tick cycles leave fgOut unchanged.
- R4: A cycle in which divSel differs from its value in the previous cycle clears the divide-by-three phase, and any tick in that cycle is ignored. The first tick that inverts fgOut is then the third tick after the change.
- R5: modeIn encodes 0 = stopped, 1 = open-loop acceleration, 2 = closed-loop run, and 3 = stopped. Outside closed-loop run, fgOut follows only the tick rules. dutyZero, uCompRaw and zeroCross have no effect on fgOut or sleepReq.
- R6: When modeIn = 2 and dutyZero = 1 in the run state, the block enters coast at the next edge. In coast, fgOut equals uCompRaw delayed by exactly three clock edges, and halfTick is ignored.
- R7: In coast, a cycle with dutyZero = 0 returns the block to the run state with a cleared divide-by-three phase.
- R8: In coast, sleepReq rises at the edge that follows the cycle in which slowLimit clock cycles have elapsed since coast entry or the last zeroCross strobe. A strobe in that same cycle restarts the window, and sleep is not entered.
- R9: While sleepReq is high, fgOut holds the synchronized comparator level sampled on the last zeroCross strobe seen outside sleep. uCompRaw, zeroCross and halfTick leave both outputs unchanged.
- R10: Sleep is left, and sleepReq falls at the next edge, only in a cycle with dutyZero = 0 and modeIn = 1. Non-zero duty with any other mode keeps the block asleep.
- R11: Leaving sleep clears the divide-by-three phase, so with divSel = 1 the third tick after exit is the first to invert fgOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | One-cycle pulse, twice per electrical cycle, from commutation |
| divSel | input | 1 | Rate select: 0 direct, 1 divide by three |
| modeIn | input | 2 | Drive mode: 0/3 stopped, 1 open-loop acceleration, 2 closed-loop run |
| dutyZero | input | 1 | Commanded PWM duty is zero |
| uCompRaw | input | 1 | Asynchronous U-phase back-EMF comparator output |
| zeroCross | input | 1 | One-cycle U-phase zero-cross detection strobe |
| slowLimit | input | GAP_W | Clock cycles equal to the 10 Hz (100 ms) window |
| fgOut | output | 1 | Registered speed-feedback pin level |
| sleepReq | output | 1 | Request to enter the sleep state |

## Verification
Two pairs of events can land in one cycle.

- **Rate select and tick.** A divSel flip can arrive together with a halfTick. The random phase flips the select bit at random moments among random ticks. A bench model predicts every cycle of fgOut, and by that model the tick in the flip cycle is discarded.
- **Zero-cross and window expiry.** A zeroCross strobe can arrive in exactly the cycle in which the gap count reaches slowLimit. A directed step places the strobe on that cycle, and the bench checks that sleepReq stays low. The window then restarts from that strobe, and the bench checks that the later sleep entry is timed from it.

// File: rtl/tach_pkg.sv
package tach_pkg;

  localparam logic [1:0] MODE_STOP   = 2'd0;
  localparam logic [1:0] MODE_OPEN   = 2'd1;
  localparam logic [1:0] MODE_CLOSED = 2'd2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_COAST = 2'd1,
    ST_SLEEP = 2'd2
  } tach_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useDiv;   // pin driven from tick divider
    logic useComp;  // pin driven from synchronized comparator
    logic hold;     // pin frozen at captured zero-cross level
    logic clrDiv;   // clear divider phase (re-entering run)
    logic grabZc;   // capture comparator level at zero-cross
  } tach_strb_t;

endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/tach_ctrl.sv
module tach_ctrl
  import tach_pkg::*;
#(
  parameter int GAP_W = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeIn,
  input  logic             dutyZero,
  input  logic             zeroCross,
  input  logic [GAP_W-1:0] slowLimit,
  output tach_strb_t       strb,
  output logic             sleepReq
);

  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

  tach_state_e state, stateNxt;
  logic [GAP_W-1:0] gapCnt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (modeIn == MODE_CLOSED && dutyZero) stateNxt = ST_COAST;
      end
      ST_COAST: begin
        if (!dutyZero)                   stateNxt = ST_RUN;
        else if (zeroCross)              stateNxt = ST_COAST;
        else if (gapCnt >= slowLimit)    stateNxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!dutyZero && modeIn == MODE_OPEN) stateNxt = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_RUN;
      gapCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state != ST_COAST || zeroCross)
        gapCnt <= '0;
      else if (gapCnt != GAP_MAX)
        gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    strb.useDiv  = (state == ST_RUN);
    strb.useComp = (state == ST_COAST);
    strb.hold    = (state == ST_SLEEP);
    strb.clrDiv  = (state != ST_RUN) && (stateNxt == ST_RUN);
    strb.grabZc  = zeroCross && (state != ST_SLEEP);
  end

  assign sleepReq = (state == ST_SLEEP);

endmodule

// File: rtl/tach_dp.sv
module tach_dp
  import tach_pkg::*;
#(
  parameter int DIV_N = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  tach_strb_t strb,
  input  logic       halfTick,
  input  logic       divSel,
  input  logic       uSync,
  output logic       fgOut
);

  localparam int PH_W = $clog2(DIV_N);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_N - 1);

  logic            divSelQ;
  logic [PH_W-1:0] phase;
  logic            zcLevel;
  logic            fgQ;
  logic            selMoved;
  logic            divToggle;

  assign selMoved  = (divSel != divSelQ);
  assign divToggle = halfTick && !selMoved && (!divSel || phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSelQ <= 1'b0;
      phase   <= '0;
      zcLevel <= 1'b0;
      fgQ     <= 1'b0;
    end else begin
      divSelQ <= divSel;

      if (strb.grabZc) zcLevel <= uSync;

      if (strb.clrDiv || selMoved)
        phase <= '0;
      else if (strb.useDiv && halfTick && divSel)
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;

      if (strb.useComp)
        fgQ <= uSync;
      else if (strb.hold)
        fgQ <= zcLevel;
      else if (strb.useDiv && divToggle)
        fgQ <= ~fgQ;
    end
  end

  assign fgOut = fgQ;

endmodule

// File: rtl/tach_feedback.sv
module tach_feedback
  import tach_pkg::*;
#(
  parameter int GAP_W       = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             divSel,
  input  logic [1:0]       modeIn,
  input  logic             dutyZero,
  input  logic             uCompRaw,
  input  logic             zeroCross,
  input  logic [GAP_W-1:0] slowLimit,
  output logic             fgOut,
  output logic             sleepReq
);

  tach_strb_t strb;
  logic       uSync;

  tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn (uCompRaw),
    .dOut(uSync)
  );

  tach_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeIn   (modeIn),
    .dutyZero (dutyZero),
    .zeroCross(zeroCross),
    .slowLimit(slowLimit),
    .strb     (strb),
    .sleepReq (sleepReq)
  );

  tach_dp #(.DIV_N(3)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .halfTick(halfTick),
    .divSel  (divSel),
    .uSync   (uSync),
    .fgOut   (fgOut)
  );

endmodule

// File: rtl/tach_feedback_chk.sv
module tach_feedback_chk
  import tach_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       halfTick,
  input logic [1:0] modeIn,
  input logic       dutyZero,
  input logic       fgOut,
  input logic       sleepReq,
  input tach_strb_t strb,
  input logic       uSync
);

  // R2, R3: divider path changes the pin only after a tick cycle
  assert_no_toggle_without_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.useDiv) && !$past(halfTick)) |-> $stable(fgOut));

  // R6: coast path copies the synchronized comparator
  assert_coast_follows_comp_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.useComp) |-> (fgOut == $past(uSync)));

  // R8: sleep is only entered from coast with zero duty
  assert_sleep_from_coast_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepReq) |-> $past(strb.useComp && dutyZero));

  // R9: pin frozen while asleep
  assert_sleep_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq && $past(sleepReq)) |=> $stable(fgOut));

  // R10: sleep left only on a new start sequence
  assert_sleep_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepReq) |-> $past(!dutyZero && modeIn == MODE_OPEN));

endmodule

bind tach_feedback tach_feedback_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .halfTick(halfTick),
  .modeIn  (modeIn),
  .dutyZero(dutyZero),
  .fgOut   (fgOut),
  .sleepReq(sleepReq),
  .strb    (strb),
  .uSync   (uSync)
);

// File: tb/tach_feedback_bench.sv
`timescale 1ns/1ps
module tach_feedback_bench;

  localparam int GAP_W = 25;
  localparam int LIM   = 40;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             halfTick = 1'b0;
  logic             divSel = 1'b0;
  logic [1:0]       modeIn = 2'd0;
  logic             dutyZero = 1'b0;
  logic             uCompRaw = 1'b0;
  logic             zeroCross = 1'b0;
  logic [GAP_W-1:0] slowLimit = GAP_W'(LIM);
  logic             fgOut;
  logic             sleepReq;

  int checks = 0;
  int errors = 0;

  // bench model state for the divider path
  logic       expFg = 1'b0;
  logic [1:0] expPh = 2'd0;
  logic       prevSel = 1'b0;

  tach_feedback #(.GAP_W(GAP_W), .SYNC_STAGES(2)) u_tach_feedback (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .divSel(divSel),
    .modeIn(modeIn), .dutyZero(dutyZero), .uCompRaw(uCompRaw),
    .zeroCross(zeroCross), .slowLimit(slowLimit),
    .fgOut(fgOut), .sleepReq(sleepReq)
  );

  always #2.5 clk = ~clk;

  // next {fg, phase} from the tick rules
  function automatic logic [2:0] modelStep(input logic fg, input logic [1:0] ph,
                                           input logic tick, input logic sel,
                                           input logic psel);
    logic       f;
    logic [1:0] p;
    f = fg; p = ph;
    if (sel != psel) p = 2'd0;
    else if (tick) begin
      if (!sel) f = ~f;
      else if (ph == 2'd2) begin p = 2'd0; f = ~f; end
      else p = ph + 2'd1;
    end
    return {f, p};
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one divider-path cycle with the model advanced
  task automatic runStep(input logic tick, input logic sel);
    logic [2:0] r;
    halfTick = tick; divSel = sel;
    cyc();
    r = modelStep(expFg, expPh, tick, sel, prevSel);
    expFg = r[2]; expPh = r[1:0]; prevSel = sel;
    halfTick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    repeat (3) cyc();
    chk("R1 fg in reset", fgOut, 1'b0);
    chk("R1 sleep in reset", sleepReq, 1'b0);
    rstN = 1'b1;
    cyc();
    chk("R1 fg after reset", fgOut, 1'b0);
    chk("R1 sleep after reset", sleepReq, 1'b0);

    // random divider phase: R2 R3 R4 R5
    for (int i = 0; i < 400; i++) begin
      logic tk, sl;
      tk = ($urandom_range(0, 2) == 0);
      sl = ($urandom_range(0, 19) == 0) ? ~divSel : divSel;
      modeIn    = ($urandom_range(0, 1) == 0) ? 2'd1 : (($urandom_range(0, 1) == 0) ? 2'd0 : 2'd3);
      dutyZero  = 1'($urandom_range(0, 1));
      uCompRaw  = 1'($urandom_range(0, 1));
      zeroCross = ($urandom_range(0, 7) == 0);
      runStep(tk, sl);
      if (sl != divSel) ; // unreachable, keeps intent readable
      chk(sl ? "R3 R4 divided rate" : "R2 R4 direct rate", fgOut, expFg);
      chk("R5 no sleep outside closed loop", sleepReq, 1'b0);
    end

    // directed R4: select change coincident with tick
    zeroCross = 1'b0; dutyZero = 1'b0; modeIn = 2'd1;
    runStep(1'b0, 1'b0); runStep(1'b0, 1'b0);
    begin
      logic f0;
      f0 = fgOut;
      runStep(1'b1, 1'b1);
      chk("R4 tick on select change ignored", fgOut, f0);
      runStep(1'b1, 1'b1);
      runStep(1'b1, 1'b1);
      chk("R4 second tick after change", fgOut, f0);
      runStep(1'b1, 1'b1);
      chk("R4 third tick after change", fgOut, ~f0);
    end

    // leave model phase at 1 so a missing clear is visible later
    runStep(1'b1, 1'b1);
    chk("R3 phase one", fgOut, expFg);

    // coast: R6
    uCompRaw = 1'b1; modeIn = 2'd2; dutyZero = 1'b1;
    repeat (4) cyc();
    chk("R6 coast follows comparator", fgOut, 1'b1);
    uCompRaw = 1'b0;
    cyc(); cyc();
    chk("R6 latency two edges", fgOut, 1'b1);
    cyc();
    chk("R6 latency three edges", fgOut, 1'b0);
    halfTick = 1'b1; cyc(); halfTick = 1'b0; cyc();
    chk("R6 tick ignored in coast", fgOut, 1'b0);
    uCompRaw = 1'b1;
    repeat (3) cyc();
    chk("R6 comparator high", fgOut, 1'b1);

    // R8 window with strobe collision
    zeroCross = 1'b1; cyc(); zeroCross = 1'b0;
    repeat (LIM) cyc();
    chk("R8 awake at window edge", sleepReq, 1'b0);
    zeroCross = 1'b1; cyc(); zeroCross = 1'b0;
    chk("R8 strobe in expiry cycle restarts", sleepReq, 1'b0);
    uCompRaw = 1'b0;
    repeat (3) cyc();
    chk("R6 follows low level", fgOut, 1'b0);
    repeat (LIM - 5) cyc();
    chk("R8 still awake inside window", sleepReq, 1'b0);
    repeat (6) cyc();
    chk("R8 sleep after window", sleepReq, 1'b1);

    // R9 frozen at captured level
    chk("R9 held at zero-cross level", fgOut, 1'b1);
    for (int k = 0; k < 12; k++) begin
      uCompRaw  = k[0];
      zeroCross = k[1];
      halfTick  = k[2];
      cyc();
    end
    zeroCross = 1'b0; halfTick = 1'b0; uCompRaw = 1'b1;
    cyc();
    chk("R9 fg frozen", fgOut, 1'b1);
    chk("R9 sleep kept", sleepReq, 1'b1);

    // R10 exit condition
    dutyZero = 1'b0; modeIn = 2'd2;
    repeat (5) cyc();
    chk("R10 closed mode keeps sleep", sleepReq, 1'b1);
    modeIn = 2'd1;
    cyc();
    chk("R10 start sequence wakes", sleepReq, 1'b0);

    // R11 cleared phase after exit (divSel stayed 1)
    halfTick = 1'b1; cyc(); halfTick = 1'b0;
    chk("R11 first tick", fgOut, 1'b1);
    halfTick = 1'b1; cyc(); halfTick = 1'b0;
    chk("R11 second tick", fgOut, 1'b1);
    halfTick = 1'b1; cyc(); halfTick = 1'b0;
    chk("R11 third tick", fgOut, 1'b0);

    // R7 coast then duty restored
    uCompRaw = 1'b1; modeIn = 2'd2; dutyZero = 1'b1;
    repeat (5) cyc();
    chk("R7 coast level", fgOut, 1'b1);
    dutyZero = 1'b0;
    cyc();
    chk("R7 back to run", sleepReq, 1'b0);
    uCompRaw = 1'b0;
    halfTick = 1'b1; cyc(); cyc(); halfTick = 1'b0;
    cyc();
    chk("R7 two ticks hold", fgOut, 1'b1);
    halfTick = 1'b1; cyc(); halfTick = 1'b0;
    chk("R7 third tick toggles", fgOut, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule